// File: doc/BRIEF.md
# Paged Connection Reference Allocator

This block hands out and takes back local connection references for a switch control path. A flat availability vector with one bit per reference would need a decoder as wide as the reference space. Instead, each bank keeps a small table of availability pages, a pointer to a current page and a priority encoder that is only one page wide. A reference is formed from the bank number, the page number and the position of the lowest free bit in that page.

Several banks run side by side. A round-robin counter gives each accepted request to the next bank in turn. A bank whose current page is full moves its pointer forward by one page per cycle until it finds a free bit. If it sweeps every one of its pages without finding a free bit, it reports exhaustion. A reference is freed by clearing its bit. Freeing a reference that is already free is flagged as an error.

The default configuration has 2 banks, 8 pages per bank and 16 bits per page, which gives 8-bit references: bit 7 is the bank, bits 6:4 are the page and bits 3:0 are the bit index. `PAGES` must be a power of two.

Top module: `conn_ref_alloc`

## Requirements
- R1: After reset every reference is free, every page pointer and the round-robin counter are 0, and busy_o, done_o, exhausted_o and free_err_o are all low.
- R2: A request is accepted on a rising edge where alloc_req_i is high and busy_o is low. From the next cycle, busy_o stays high until the result cycle. An alloc_req_i pulse while busy_o is high has no effect: it is not accepted and does not advance the round robin.
- R3: If a request is accepted at edge N and its bank's current page has a free bit, done_o is high for exactly one cycle after edge N+1. In that cycle ref_o = {bank, page, bit}, where bit is the lowest index that holds 0 (0 = free, 1 = used). That bit then becomes used.
- R4: A page pointer moves only while a search finds the current page full. It then advances by one page per cycle, from PAGES-1 back to 0, and each full page skipped delays done_o by one cycle. An allocation that fills a page leaves the pointer on that page.
- R5: Accepted requests go to banks 0, 1, 0, 1, … in turn, whatever their outcome.
- R6: If all PAGES pages of the chosen bank are full, exhausted_o is high for one cycle after edge N+PAGES. In that case done_o does not rise, and the pointer ends on the page where it started.
- R7: A free_req_i pulse whose free_ref_i names a used reference clears that bit, so the reference can be allocated again, and free_err_o stays low.
- R8: A free_req_i pulse whose reference is already free raises free_err_o for one cycle after that edge and changes no bit.
- R9: A free that falls on the same edge as a successful search takes effect together with the allocation. The search chooses its bit from the page contents before that free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Allocation request |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | ref_o holds a newly allocated reference |
| ref_o | output | 8 | Allocated reference {bank, page, bit} |
| exhausted_o | output | 1 | The chosen bank has no free reference |
| free_req_i | input | 1 | Free request |
| free_ref_i | input | 8 | Reference to free |
| free_err_o | output | 1 | The freed reference was already free |

## Verification
A free and the completion of an allocation can land on the same clock edge in the same page, so that one edge both sets one bit and clears another. The bench fills every reference of both banks. It then frees one bit ahead of a search that has to skip a full page, and drives a second free in that page so that it lands exactly on the edge where the search completes. The bench checks that the reported reference is the bit that was free before that edge, that the free raises no error, and that a later allocation returns the bit the concurrent free released.

// File: rtl/conn_ref_pkg.sv
package conn_ref_pkg;
  // index width that stays at least one bit for single-entry counts
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/free_bit_enc.sv
module free_bit_enc #(
  parameter int W = 16,
  localparam int IW = conn_ref_pkg::idx_w(W)
) (
  input  logic [W-1:0]  used_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/conn_ref_bank.sv
module conn_ref_bank #(
  parameter int PAGES     = 8,
  parameter int PAGE_BITS = 16,
  localparam int PW = conn_ref_pkg::idx_w(PAGES),
  localparam int BW = conn_ref_pkg::idx_w(PAGE_BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          free_i,
  input  logic [PW-1:0] free_page_i,
  input  logic [BW-1:0] free_bit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [PW-1:0] page_o,
  output logic [BW-1:0] bit_o,
  output logic          exh_o,
  output logic          free_err_o
);
  logic [PAGE_BITS-1:0] tbl_q [PAGES];
  logic [PAGE_BITS-1:0] tbl_d [PAGES];
  logic [PW-1:0]        ptr_q;
  logic [PW:0]          sweep_q;
  logic                 found;
  logic [BW-1:0]        idx;
  logic                 alloc_fire, free_ok, free_bad;

  free_bit_enc #(.W(PAGE_BITS)) u_enc (
    .used_i (tbl_q[ptr_q]),
    .found_o(found),
    .idx_o  (idx)
  );

  assign alloc_fire = busy_o && found;
  assign free_ok    = free_i && tbl_q[free_page_i][free_bit_i];
  assign free_bad   = free_i && !tbl_q[free_page_i][free_bit_i];

  always_comb begin
    for (int p = 0; p < PAGES; p++) begin
      tbl_d[p] = tbl_q[p];
      if (alloc_fire && ptr_q == PW'(p)) tbl_d[p][idx] = 1'b1;
      // clear can never hit the bit being set: that bit was 0
      if (free_ok && free_page_i == PW'(p)) tbl_d[p][free_bit_i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < PAGES; p++) tbl_q[p] <= '0;
      ptr_q      <= '0;
      sweep_q    <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      exh_o      <= 1'b0;
      free_err_o <= 1'b0;
      page_o     <= '0;
      bit_o      <= '0;
    end else begin
      for (int p = 0; p < PAGES; p++) tbl_q[p] <= tbl_d[p];
      done_o     <= 1'b0;
      exh_o      <= 1'b0;
      free_err_o <= free_bad;
      if (start_i && !busy_o) begin
        busy_o  <= 1'b1;
        sweep_q <= '0;
      end else if (busy_o) begin
        if (found) begin
          done_o <= 1'b1;
          page_o <= ptr_q;
          bit_o  <= idx;
          busy_o <= 1'b0;
        end else begin
          ptr_q <= (ptr_q == PW'(PAGES - 1)) ? '0 : ptr_q + 1'b1;
          if (sweep_q == (PW + 1)'(PAGES - 1)) begin
            exh_o  <= 1'b1;
            busy_o <= 1'b0;
          end else begin
            sweep_q <= sweep_q + 1'b1;
          end
        end
      end
    end
  end

  // R3: a reported reference is marked used
  a_r3_done_marks_used: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tbl_q[page_o][bit_o]);
  // R4: pointer holds while idle
  a_r4_ptr_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(ptr_q));
  // R8: error pulse only follows a free request
  a_r8_err_after_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_err_o |-> $past(free_i));
  // R6: success and exhaustion exclusive
  a_r6_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && exh_o));
endmodule

// File: rtl/conn_ref_alloc.sv
module conn_ref_alloc #(
  parameter int N_BANKS   = 2,
  parameter int PAGES     = 8,
  parameter int PAGE_BITS = 16,
  localparam int KW    = conn_ref_pkg::idx_w(N_BANKS),
  localparam int PW    = conn_ref_pkg::idx_w(PAGES),
  localparam int BW    = conn_ref_pkg::idx_w(PAGE_BITS),
  localparam int REF_W = KW + PW + BW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [REF_W-1:0] ref_o,
  output logic             exhausted_o,
  input  logic             free_req_i,
  input  logic [REF_W-1:0] free_ref_i,
  output logic             free_err_o
);
  logic [KW-1:0]      rr_q;
  logic               accept;
  logic [N_BANKS-1:0] bk_busy, bk_done, bk_exh, bk_err;
  logic [PW-1:0]      bk_page [N_BANKS];
  logic [BW-1:0]      bk_bit  [N_BANKS];
  logic [KW-1:0]      free_bank;

  assign accept    = alloc_req_i && !busy_o;
  assign free_bank = (N_BANKS > 1) ? free_ref_i[REF_W-1 -: KW] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (accept) rr_q <= (rr_q == KW'(N_BANKS - 1)) ? '0 : rr_q + 1'b1;
  end

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    conn_ref_bank #(.PAGES(PAGES), .PAGE_BITS(PAGE_BITS)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (accept && rr_q == KW'(b)),
      .free_i     (free_req_i && free_bank == KW'(b)),
      .free_page_i(free_ref_i[BW +: PW]),
      .free_bit_i (free_ref_i[BW-1:0]),
      .busy_o     (bk_busy[b]),
      .done_o     (bk_done[b]),
      .page_o     (bk_page[b]),
      .bit_o      (bk_bit[b]),
      .exh_o      (bk_exh[b]),
      .free_err_o (bk_err[b])
    );
  end

  assign busy_o      = |bk_busy;
  assign done_o      = |bk_done;
  assign exhausted_o = |bk_exh;
  assign free_err_o  = |bk_err;

  always_comb begin
    ref_o = '0;
    for (int b = 0; b < N_BANKS; b++)
      if (bk_done[b]) ref_o = {KW'(b), bk_page[b], bk_bit[b]};
  end

  // R2: at most one bank searches at a time
  a_r2_single_search: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bk_busy));
  // R5: results come from one bank only
  a_r5_single_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bk_done | bk_exh));
  // R2: a result ends the search
  a_r2_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || exhausted_o) |-> !busy_o);
endmodule

// File: tb/conn_ref_alloc_tb.sv
module conn_ref_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PAGES = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       alloc_req_i = 1'b0;
  logic       free_req_i = 1'b0;
  logic [7:0] free_ref_i = '0;
  logic       busy_o, done_o, exhausted_o, free_err_o;
  logic [7:0] ref_o;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  conn_ref_alloc u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_req_i(alloc_req_i), .busy_o(busy_o),
    .done_o(done_o), .ref_o(ref_o), .exhausted_o(exhausted_o),
    .free_req_i(free_req_i), .free_ref_i(free_ref_i), .free_err_o(free_err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; result sampled at the negedge after edge N+j
  task automatic do_alloc(input bit exp_exh, input logic [7:0] exp_ref, input int exp_lat,
                          input int free_j, input logic [7:0] fref, input int poke_j,
                          input string tag);
    int  j;
    bit  got;
    @(negedge clk_i);
    alloc_req_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    alloc_req_i = 1'b0;
    chk(busy_o == 1'b1, {tag, " R2 busy"}, busy_o, 1);
    got = 1'b0;
    j = 0;
    while (!got && j < 40) begin
      j++;
      free_req_i  = (j == free_j);
      free_ref_i  = fref;
      alloc_req_i = (j == poke_j);
      @(negedge clk_i);
      alloc_req_i = 1'b0;
      free_req_i  = 1'b0;
      if (j == free_j) chk(free_err_o == 1'b0, {tag, " R9 free err"}, free_err_o, 0);
      got = done_o || exhausted_o;
      if (!got) chk(busy_o == 1'b1, {tag, " R2 still busy"}, busy_o, 1);
    end
    chk(j == exp_lat, {tag, " R4 latency"}, j, exp_lat);
    chk(exhausted_o == exp_exh && done_o == !exp_exh, {tag, " R6 outcome"},
        {exhausted_o, done_o}, {exp_exh, !exp_exh});
    if (!exp_exh) chk(ref_o == exp_ref, {tag, " R3 ref"}, ref_o, exp_ref);
    @(negedge clk_i);
    chk(!done_o && !exhausted_o, {tag, " R3 one-cycle pulse"}, {done_o, exhausted_o}, 0);
  endtask

  task automatic do_free(input logic [7:0] r, input bit exp_err, input string tag);
    @(negedge clk_i);
    free_req_i = 1'b1;
    free_ref_i = r;
    @(negedge clk_i);
    free_req_i = 1'b0;
    chk(free_err_o == exp_err, {tag, " R8 err flag"}, free_err_o, exp_err);
    @(negedge clk_i);
    chk(free_err_o == 1'b0, {tag, " R8 err pulse"}, free_err_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !exhausted_o && !free_err_o, "R1 reset outputs",
        {busy_o, done_o, exhausted_o, free_err_o}, 0);
    rst_ni = 1'b1;
    // fill: bank alternates (R5), lowest bit first (R3), skip on full page (R4)
    for (int i = 0; i < 256; i++) begin
      int b, n, lat;
      b = i % 2;
      n = i / 2;
      lat = (n % 16 == 0 && n > 0) ? 2 : 1;
      do_alloc(1'b0, 8'(b * 128 + (n / 16) * 16 + n % 16), lat, 0, 8'h00, 0, "R5 fill");
    end
    do_alloc(1'b1, 8'h00, PAGES, 0, 8'h00, 0, "R6 bank0 full");
    do_alloc(1'b1, 8'h00, PAGES, 0, 8'h00, 0, "R6 bank1 full");
    do_free(8'h35, 1'b0, "R7 free 35");
    do_free(8'h32, 1'b0, "R7 free 32");
    do_free(8'h89, 1'b0, "R7 free 89");
    do_free(8'h35, 1'b1, "R8 double free 35");
    // bank0 pointer at 7: skips 7,0,1,2
    do_alloc(1'b0, 8'h32, 5, 0, 8'h00, 0, "R4 wrap search");
    do_alloc(1'b0, 8'h89, 2, 0, 8'h00, 0, "R4 bank1 wrap");
    do_alloc(1'b0, 8'h35, 1, 0, 8'h00, 0, "R8 table unchanged");
    do_free(8'h4C, 1'b0, "R7 free 4C");
    do_alloc(1'b1, 8'h00, PAGES, 0, 8'h00, 3, "R2 ignored poke");
    // poke ignored: this must go to bank0
    do_alloc(1'b0, 8'h4C, 2, 2, 8'h41, 0, "R9 concurrent free");
    do_alloc(1'b1, 8'h00, PAGES, 0, 8'h00, 0, "R6 bank1 again");
    do_alloc(1'b0, 8'h41, 1, 0, 8'h00, 0, "R9 freed bit reused");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule